// File: doc/BRIEF.md
# Supply Brown-Out Reset Sequencer

This block converts the digital output of a supply-voltage comparator into a clean internal reset request. The comparator reports "supply low" or "supply ok". The block synchronizes that indication and filters out short spikes in both directions. It holds reset for as long as the filtered state says the supply is low. After the supply recovers, it keeps reset asserted for a further stabilization interval so that the oscillator can settle.

Detection is enabled by a single control bit, which software writes through a write strobe and data bit. The bit is cleared by the power-on reset, so detection starts disabled. Detection is also suspended while the device is in halt mode. Only the power-on reset clears the block; the reset it generates never feeds back into it.

Top module: `bor_sequencer`

## Requirements
- R1: While detection is active and the filtered supply state is low, `bor_rst_o` is 1. After `supply_low_i` rises and stays high, `bor_rst_o` goes to 1 after exactly FILT_LEN+4 rising clock edges.
- R2: A change of the synchronized comparator value, in either direction, is accepted only after it has held for FILT_LEN+1 consecutive cycles. An excursion of FILT_LEN cycles or fewer leaves the filtered state and `bor_rst_o` unchanged.
- R3: Once the filtered state returns to ok, `bor_rst_o` stays 1 for HOLD_LEN further cycles. When `supply_low_i` falls, the release happens after edge FILT_LEN+HOLD_LEN+4.
- R4: While `halt_i` is 1, `bor_rst_o` is 0 in the same cycle, and the filter and release counters are cleared. When `halt_i` returns to 0, filtering restarts from an empty count.
- R5: The enable bit is loaded from `en_wdata_i` on a clock edge where `en_we_i` is 1, and it reads 0 after power-on reset. While it is 0, `supply_low_i` has no effect on `bor_rst_o` or `low_flag_o`.
- R6: Only `por_n` (asynchronous, active low) clears the block. It forces `bor_rst_o` and `low_flag_o` to 0 at once and clears the enable bit.
- R7: If the filtered state goes low again during the release interval, the release count is reloaded and `bor_rst_o` stays 1 without a gap. A later recovery waits the full HOLD_LEN again.
- R8: Clearing the enable bit while `bor_rst_o` is 1 drops `bor_rst_o` after the clock edge that loads the 0. The filter is emptied, so after re-enabling, a low supply needs a full filter interval before reset is asserted.
- R9: `low_flag_o` shows the filtered supply state (1 = low). It changes one edge before `bor_rst_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| supply_low_i | input | 1 | Comparator output, 1 = supply below threshold |
| halt_i | input | 1 | Device is in halt mode |
| en_we_i | input | 1 | Write strobe for the detection enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| bor_rst_o | output | 1 | Reset request to the rest of the device |
| low_flag_o | output | 1 | Filtered supply-low status |

## Verification
The hardest case to reach is a recovery that is interrupted. The filtered state must be driven back to low during the release interval, after the release count has started but before it expires. The bench does this by counting edges from the moment the comparator input is dropped and raising it again part way through the interval. It also drives excursions exactly one cycle shorter and exactly as long as the filter threshold, in both directions, and clears the enable bit mid-reset to show that the filter count restarts from zero.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    BOR_IDLE  = 2'd0,
    BOR_HOLD  = 2'd1,
    BOR_DELAY = 2'd2
  } bor_state_e;

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/bor_glitch_filter.sv
module bor_glitch_filter #(
  parameter int FILT_LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic sample_i,
  output logic filt_o
);

  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             filt_q, filt_d;

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    if (!active_i) begin
      cnt_d  = '0;
      filt_d = 1'b0;
    end else if (sample_i == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_TOP) begin
      filt_d = sample_i;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/bor_release_timer.sv
module bor_release_timer
  import bor_pkg::*;
#(
  parameter int HOLD_LEN = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic low_i,
  output logic req_o
);

  localparam int DLY_W = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(HOLD_LEN - 1);

  bor_state_e       state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    if (!active_i) begin
      state_d = BOR_IDLE;
      dly_d   = '0;
    end else begin
      unique case (state_q)
        BOR_IDLE: begin
          dly_d = '0;
          if (low_i) state_d = BOR_HOLD;
        end
        BOR_HOLD: begin
          dly_d = '0;
          if (!low_i) state_d = BOR_DELAY;
        end
        BOR_DELAY: begin
          if (low_i) begin
            state_d = BOR_HOLD;
            dly_d   = '0;
          end else if (dly_q == DLY_LAST) begin
            state_d = BOR_IDLE;
            dly_d   = '0;
          end else begin
            dly_d = dly_q + 1'b1;
          end
        end
        default: begin
          state_d = BOR_IDLE;
          dly_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BOR_IDLE;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
    end
  end

  assign req_o = (state_q != BOR_IDLE);

endmodule

// File: rtl/bor_sequencer.sv
module bor_sequencer #(
  parameter int FILT_LEN    = 100,
  parameter int HOLD_LEN    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low_i,
  input  logic halt_i,
  input  logic en_we_i,
  input  logic en_wdata_i,
  output logic bor_rst_o,
  output logic low_flag_o
);

  logic en_q, en_d;
  logic active;
  logic sync_low;
  logic filt_low;
  logic hold_req;

  // enable bit: next-state and register kept apart
  always_comb begin
    en_d = en_q;
    if (en_we_i) en_d = en_wdata_i;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign active = en_q & ~halt_i;

  bor_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_i   (supply_low_i),
    .q_o   (sync_low)
  );

  bor_glitch_filter #(
    .FILT_LEN (FILT_LEN)
  ) u_filt (
    .clk      (clk),
    .rst_n    (por_n),
    .active_i (active),
    .sample_i (sync_low),
    .filt_o   (filt_low)
  );

  bor_release_timer #(
    .HOLD_LEN (HOLD_LEN)
  ) u_timer (
    .clk      (clk),
    .rst_n    (por_n),
    .active_i (active),
    .low_i    (filt_low),
    .req_o    (hold_req)
  );

  assign bor_rst_o  = hold_req & active;
  assign low_flag_o = filt_low;

endmodule

// File: rtl/bor_sequencer_chk.sv
module bor_sequencer_chk #(
  parameter int FILT_LEN = 100,
  parameter int HOLD_LEN = 4096
) (
  input logic clk,
  input logic por_n,
  input logic halt_i,
  input logic en_q,
  input logic sync_q,
  input logic low_flag_o,
  input logic bor_rst_o
);

  logic        act;
  logic [31:0] hi_run, lo_run, ok_run;

  assign act = en_q & ~halt_i;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_run <= '0;
      lo_run <= '0;
      ok_run <= '0;
    end else begin
      hi_run <= sync_q  ? ((hi_run == 32'hFFFF_FFFF) ? hi_run : hi_run + 1) : '0;
      lo_run <= !sync_q ? ((lo_run == 32'hFFFF_FFFF) ? lo_run : lo_run + 1) : '0;
      ok_run <= !low_flag_o ? ((ok_run == 32'hFFFF_FFFF) ? ok_run : ok_run + 1) : '0;
    end
  end

  // R1: filtered low while active keeps reset asserted
  p_rst_while_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    (act && low_flag_o) |=> (bor_rst_o || !act));

  // R2: filtered state rises only after a long enough run of low samples
  p_rise_filtered_r2: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(low_flag_o) && $past(act)) |-> (hi_run > 32'(FILT_LEN)));

  // R2: filtered state falls only after a long enough run of ok samples
  p_fall_filtered_r2: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(low_flag_o) && $past(act)) |-> (lo_run > 32'(FILT_LEN)));

  // R3: release comes only after the full stabilization interval
  p_release_wait_r3: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(bor_rst_o) && act && $past(act)) |-> (ok_run >= 32'(HOLD_LEN)));

  // R4: halt keeps reset low
  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
    halt_i |-> !bor_rst_o);

  // R5: disabled detection never requests reset
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
    !en_q |-> !bor_rst_o);

endmodule

bind bor_sequencer bor_sequencer_chk #(
  .FILT_LEN (FILT_LEN),
  .HOLD_LEN (HOLD_LEN)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .halt_i     (halt_i),
  .en_q       (en_q),
  .sync_q     (sync_low),
  .low_flag_o (low_flag_o),
  .bor_rst_o  (bor_rst_o)
);

// File: tb/tb_bor_sequencer.sv
`timescale 1ns/1ps
module tb_bor_sequencer;

  localparam int FL = 8;
  localparam int HL = 32;
  localparam int NV = 8;
  // glitch widths and whether each must trip reset (R2: trip iff width >= FL+1)
  localparam int VEC_W  [NV] = '{1, 3, 6, 7, 8, 9, 12, 20};
  localparam bit VEC_EX [NV] = '{0, 0, 0, 0, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic por_n, supply_low, halt, en_we, en_wdata;
  logic bor_rst, low_flag;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  bor_sequencer #(.FILT_LEN(FL), .HOLD_LEN(HL)) dut (
    .clk(clk), .por_n(por_n), .supply_low_i(supply_low), .halt_i(halt),
    .en_we_i(en_we), .en_wdata_i(en_wdata),
    .bor_rst_o(bor_rst), .low_flag_o(low_flag));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic write_en(input logic v);
    en_we = 1'b1; en_wdata = v;
    tick(1);
    en_we = 1'b0;
  endtask

  task automatic go_hold();
    supply_low = 1'b1;
    tick(FL + 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; supply_low = 1'b0; halt = 1'b0; en_we = 1'b0; en_wdata = 1'b0;
    tick(3);
    chk(bor_rst, 1'b0, "R6 reset state rst");
    chk(low_flag, 1'b0, "R6 reset state flag");
    por_n = 1'b1;
    tick(2);

    // R5: disabled after power-on, low supply ignored
    supply_low = 1'b1;
    tick(FL + HL + 20);
    chk(bor_rst, 1'b0, "R5 disabled rst");
    chk(low_flag, 1'b0, "R5 disabled flag");
    supply_low = 1'b0;
    tick(5);
    write_en(1'b1);

    // R2: table of glitch widths
    for (int i = 0; i < NV; i++) begin
      logic saw = 1'b0;
      supply_low = 1'b1;
      tick(VEC_W[i]);
      supply_low = 1'b0;
      for (int k = 0; k < VEC_W[i] + 20; k++) begin
        saw |= bor_rst;
        tick(1);
      end
      chk(saw, VEC_EX[i], $sformatf("R2 glitch width %0d", VEC_W[i]));
      tick(FL + HL + 10);
      chk(bor_rst, 1'b0, "R3 idle after vector");
    end

    // R1 / R9: exact assertion latency
    supply_low = 1'b1;
    tick(FL + 3);
    chk(low_flag, 1'b1, "R9 flag ahead of reset");
    chk(bor_rst, 1'b0, "R1 not yet asserted");
    tick(1);
    chk(bor_rst, 1'b1, "R1 asserted at latency");
    tick(100);
    chk(bor_rst, 1'b1, "R1 held while low");

    // R3: exact release latency
    supply_low = 1'b0;
    tick(FL + 3);
    chk(low_flag, 1'b0, "R9 flag back to ok");
    tick(HL);
    chk(bor_rst, 1'b1, "R3 still held last cycle");
    tick(1);
    chk(bor_rst, 1'b0, "R3 released");

    // R2: short ok excursion during hold ignored
    go_hold();
    supply_low = 1'b0;
    tick(FL);
    supply_low = 1'b1;
    tick(30);
    chk(low_flag, 1'b1, "R2 short ok spike flag");
    chk(bor_rst, 1'b1, "R2 short ok spike rst");

    // R7: supply drops again inside release interval
    begin
      logic gap = 1'b0;
      supply_low = 1'b0;
      for (int k = 0; k < FL + 14; k++) begin gap |= !bor_rst; tick(1); end
      supply_low = 1'b1;
      for (int k = 0; k < FL + HL; k++) begin gap |= !bor_rst; tick(1); end
      chk(gap, 1'b0, "R7 no gap on reload");
    end
    supply_low = 1'b0;
    tick(FL + 3 + HL);
    chk(bor_rst, 1'b1, "R7 full wait after reload");
    tick(1);
    chk(bor_rst, 1'b0, "R7 release after reload");

    // R8: disable during reset, then filter restarts
    go_hold();
    chk(bor_rst, 1'b1, "R8 in hold");
    write_en(1'b0);
    chk(bor_rst, 1'b0, "R8 released on disable");
    tick(3);
    write_en(1'b1);
    tick(FL);
    chk(low_flag, 1'b0, "R8 filter restarted");
    tick(1);
    chk(low_flag, 1'b1, "R8 filter full count");
    chk(bor_rst, 1'b0, "R8 rst after flag");
    tick(1);
    chk(bor_rst, 1'b1, "R8 reasserted");

    // R4: halt suspends detection
    halt = 1'b1;
    #1;
    chk(bor_rst, 1'b0, "R4 halt drops rst");
    tick(20);
    chk(bor_rst, 1'b0, "R4 halt rst");
    chk(low_flag, 1'b0, "R4 halt flag cleared");
    halt = 1'b0;
    tick(FL + 1);
    chk(low_flag, 1'b1, "R4 refilter after halt");
    chk(bor_rst, 1'b0, "R4 rst waits");
    tick(1);
    chk(bor_rst, 1'b1, "R4 reasserted after halt");

    // R6: power-on reset clears everything including the enable
    por_n = 1'b0;
    #1;
    chk(bor_rst, 1'b0, "R6 por drops rst");
    chk(low_flag, 1'b0, "R6 por drops flag");
    tick(2);
    por_n = 1'b1;
    tick(FL + HL + 20);
    chk(bor_rst, 1'b0, "R6 enable cleared by por");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule